// File: doc/BRIEF.md
# Halfword Instruction Prefetch Unit

This block is the fetch stage of a two-stage pipeline whose instructions are mostly 16 bits long. It reads program memory one 32-bit word at a time and splits each word into two halfword instructions. It hands out one halfword per cycle to the decode stage over a valid/ready handshake. A word supplies two instruction slots, so in straight-line code memory is read only on alternate cycles. A halfword is available in the same cycle its memory response arrives, which lets the pre-decode logic work on it at the end of fetch.

When decode signals a taken branch, the unit discards everything it holds and drops a memory response that arrives in that cycle. It then requests the target in that same cycle. A target that is halfword aligned but not word aligned is fetched with a 16-bit transfer that returns only the upper halfword of its word, and word reads resume from the next word. Because a new read is issued only once the buffer would otherwise run dry, no more than one word of wrong-path work is ever thrown away.

A small state machine tracks the memory side. FS_IDLE means no request and no response is due. FS_STALL means a request is held because memory is not ready. FS_RESP_WORD and FS_RESP_HALF mean a word or a halfword response is due in the current cycle. An accepted word request moves to FS_RESP_WORD and an accepted halfword request moves to FS_RESP_HALF. A request that is not accepted moves to FS_STALL. A cycle with no request returns to FS_IDLE. All four states follow these same transition rules.

Top module: `hw_prefetch_unit`

## Requirements
- R1: In the first cycle after reset, `ins_valid` is 0 and a word read (`mem_size`=1) of `RESET_ADDR` is requested.
- R2: A word read at aligned address A delivers bits 15:0 as the instruction at A and then bits 31:16 as the instruction at A+2. Each accepted instruction is followed by the one at the next halfword address unless a branch intervenes.
- R3: With memory always ready and decode always accepting, `ins_valid` is 1 in every cycle from the first response on, and reads are accepted on every other cycle: 20 reads in 40 cycles.
- R4: A read is requested only when the held halfwords plus the halfwords arriving this cycle, minus the one taken, come to zero. The unit never holds more than two halfwords, so if decode stalls with instructions held, no read is issued.
- R5: A branch flushes the held instructions and drops a response that arrives in the branch cycle. A decode handshake in the branch cycle consumes nothing. The next instruction delivered is the one at the target.
- R6: In the branch cycle, a read of the target is requested. When memory accepts it, the target instruction is valid in the next cycle.
- R7: A target with address bit 1 set is fetched with `mem_size`=0 and delivers bits 31:16 of the returned word. The next read is a word read at target+2.
- R8: After an accepted word read the fetch address grows by 4, and after a halfword read it grows by 2. Bit 0 of every program address is 0, and bit 0 of `br_target` is ignored.
- R9: While `mem_ready` is 0 and no branch arrives, `mem_req` stays high with `mem_addr` and `mem_size` unchanged.
- R10: In back-to-back branches each redirect overrides the previous one, and the last target is the next instruction delivered.
- R11: While `ins_valid` is 1 and `ins_ready` is 0 with no branch, `ins_data` and `ins_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_req | output | 1 | Program memory read request |
| mem_addr | output | ADDR_W | Read address (byte address, bit 0 zero) |
| mem_size | output | 1 | 1 = 32-bit transfer, 0 = 16-bit transfer |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Word containing the address, returned the cycle after acceptance |
| ins_valid | output | 1 | A halfword instruction is offered to decode |
| ins_ready | input | 1 | Decode takes the offered instruction |
| ins_data | output | 16 | Offered instruction halfword |
| ins_addr | output | ADDR_W | Address of the offered instruction |
| br_valid | input | 1 | Taken branch: redirect fetch |
| br_target | input | ADDR_W | Branch target address |

## Verification
A read accepted at one clock edge has its response on `mem_rdata` during the following cycle. Its halfwords appear on `ins_valid`/`ins_data` in that same cycle, so a redirect accepted immediately shows the target one cycle after `br_valid`. Request outputs react to `br_valid` and to buffer level in the same cycle, with no register in between. The bench therefore drives every input after the falling edge, lets the combinational paths settle, and compares the request, the offered instruction and the read counts before the next rising edge. Its model of the expected instruction address and fetch address advances only at that edge.

// File: rtl/pf_pkg.sv
package pf_pkg;

    localparam int HALF_W  = 16;
    localparam int WORD_W  = 32;
    localparam int SLOTS   = 2;
    localparam int LEVEL_W = $clog2(2 * SLOTS);

    typedef enum logic [1:0] {
        FS_IDLE      = 2'd0,
        FS_STALL     = 2'd1,
        FS_RESP_WORD = 2'd2,
        FS_RESP_HALF = 2'd3
    } fetch_state_e;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [WORD_W-1:0] word_t;

endpackage

// File: rtl/pf_fetch_ctrl.sv
module pf_fetch_ctrl
    import pf_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_target,
    input  logic              need_fetch,
    input  logic              mem_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_size,
    output logic              rsp_word,
    output logic              rsp_half,
    output logic [ADDR_W-1:0] rsp_addr
);

    localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] STEP_HALF = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] EVEN_MASK = ~ADDR_W'(1);

    fetch_state_e      state_q, state_d;
    logic [ADDR_W-1:0] fa_q, fa_d;
    logic [ADDR_W-1:0] ra_q, ra_d;
    logic [ADDR_W-1:0] req_addr;
    logic              req_word;
    logic              accept;

    // request selection: a redirect overrides the running fetch address
    always_comb begin
        req_addr = br_valid ? (br_target & EVEN_MASK) : (fa_q & EVEN_MASK);
        req_word = ~req_addr[1];
        accept   = (br_valid | need_fetch) & mem_ready;
    end

    // next-state and address logic
    always_comb begin
        state_d = state_q;
        fa_d    = req_addr;
        ra_d    = ra_q;
        if (accept) begin
            fa_d = req_addr + (req_word ? STEP_WORD : STEP_HALF);
            ra_d = req_addr;
        end
        unique case (state_q)
            FS_IDLE, FS_STALL, FS_RESP_WORD, FS_RESP_HALF: begin
                if (accept) begin
                    state_d = req_word ? FS_RESP_WORD : FS_RESP_HALF;
                end else if (br_valid | need_fetch) begin
                    state_d = FS_STALL;
                end else begin
                    state_d = FS_IDLE;
                end
            end
            default: state_d = FS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            fa_q    <= RESET_ADDR & EVEN_MASK;
            ra_q    <= '0;
        end else begin
            state_q <= state_d;
            fa_q    <= fa_d;
            ra_q    <= ra_d;
        end
    end

    // outputs
    always_comb begin
        mem_req  = br_valid | need_fetch;
        mem_addr = req_addr;
        mem_size = req_word;
        rsp_word = 1'b0;
        rsp_half = 1'b0;
        rsp_addr = ra_q;
        unique case (state_q)
            FS_RESP_WORD: rsp_word = 1'b1;
            FS_RESP_HALF: rsp_half = 1'b1;
            default: begin
                rsp_word = 1'b0;
                rsp_half = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pf_hw_queue.sv
module pf_hw_queue
    import pf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               rsp_word,
    input  logic               rsp_half,
    input  logic [ADDR_W-1:0]  rsp_addr,
    input  word_t              rsp_data,
    input  logic               out_ready,
    output logic               out_valid,
    output half_t              out_data,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               need_fetch,
    output logic [LEVEL_W:0]   level
);

    localparam int CAND = 2 * SLOTS;

    half_t             sd_q [SLOTS];
    logic [ADDR_W-1:0] sa_q [SLOTS];
    half_t             sd_d [SLOTS];
    logic [ADDR_W-1:0] sa_d [SLOTS];
    logic [1:0]        cnt_q, cnt_d;

    half_t             cd [CAND];
    logic [ADDR_W-1:0] ca [CAND];
    half_t             inc_d [2];
    logic [ADDR_W-1:0] inc_a [2];
    logic [1:0]        inc_n;
    logic [1:0]        idx1;
    logic [LEVEL_W:0]  avail;
    logic [LEVEL_W:0]  remain;
    logic              pop;

    // incoming halfwords from the response in this cycle
    always_comb begin
        inc_d[0] = rsp_word ? rsp_data[15:0] : rsp_data[31:16];
        inc_a[0] = rsp_addr;
        inc_d[1] = rsp_data[31:16];
        inc_a[1] = rsp_addr + ADDR_W'(2);
        inc_n    = rsp_word ? 2'd2 : (rsp_half ? 2'd1 : 2'd0);
    end

    // combined view: held halfwords first, then incoming ones
    always_comb begin
        for (int i = 0; i < CAND; i++) begin
            cd[i] = '0;
            ca[i] = '0;
        end
        for (int i = 0; i < SLOTS; i++) begin
            cd[i] = sd_q[i];
            ca[i] = sa_q[i];
        end
        idx1 = cnt_q + 2'd1;
        if (inc_n != 2'd0) begin
            cd[cnt_q] = inc_d[0];
            ca[cnt_q] = inc_a[0];
        end
        if (inc_n == 2'd2) begin
            cd[idx1] = inc_d[1];
            ca[idx1] = inc_a[1];
        end
        avail      = {1'b0, cnt_q} + {1'b0, inc_n};
        out_valid  = (avail != '0);
        out_data   = cd[0];
        out_addr   = ca[0];
        pop        = out_valid & out_ready & ~flush;
        remain     = avail - {{LEVEL_W{1'b0}}, pop};
        need_fetch = (remain == '0);
        level      = avail;
    end

    // advance the queue
    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            always_comb begin
                sd_d[g] = pop ? cd[g+1] : cd[g];
                sa_d[g] = pop ? ca[g+1] : ca[g];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sd_q[g] <= '0;
                    sa_q[g] <= '0;
                end else begin
                    sd_q[g] <= sd_d[g];
                    sa_q[g] <= sa_d[g];
                end
            end
        end
    endgenerate

    always_comb begin
        cnt_d = flush ? 2'd0 : remain[1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= 2'd0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/hw_prefetch_unit.sv
module hw_prefetch_unit
    import pf_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_size,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic              ins_valid,
    input  logic              ins_ready,
    output logic [15:0]       ins_data,
    output logic [ADDR_W-1:0] ins_addr,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_target
);

    logic              need_fetch;
    logic              rsp_word;
    logic              rsp_half;
    logic [ADDR_W-1:0] rsp_addr;
    logic [LEVEL_W:0]  q_level;

    pf_fetch_ctrl #(
        .ADDR_W    (ADDR_W),
        .RESET_ADDR(RESET_ADDR)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .br_valid  (br_valid),
        .br_target (br_target),
        .need_fetch(need_fetch),
        .mem_ready (mem_ready),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_size  (mem_size),
        .rsp_word  (rsp_word),
        .rsp_half  (rsp_half),
        .rsp_addr  (rsp_addr)
    );

    pf_hw_queue #(
        .ADDR_W(ADDR_W)
    ) queue_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (br_valid),
        .rsp_word  (rsp_word),
        .rsp_half  (rsp_half),
        .rsp_addr  (rsp_addr),
        .rsp_data  (mem_rdata),
        .out_ready (ins_ready),
        .out_valid (ins_valid),
        .out_data  (ins_data),
        .out_addr  (ins_addr),
        .need_fetch(need_fetch),
        .level     (q_level)
    );

endmodule

// File: rtl/hw_prefetch_unit_chk.sv
module hw_prefetch_unit_chk
    import pf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_size,
    input logic              mem_ready,
    input logic              ins_valid,
    input logic              ins_ready,
    input logic [15:0]       ins_data,
    input logic [ADDR_W-1:0] ins_addr,
    input logic              br_valid,
    input logic [ADDR_W-1:0] br_target,
    input logic [LEVEL_W:0]  q_level
);

    // R2: sequential order of delivered instructions
    p_seq_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && ins_ready && !br_valid |=> !ins_valid || ins_addr == $past(ins_addr) + ADDR_W'(2));

    // R4: never more than one word of halfwords held or arriving
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q_level <= (LEVEL_W+1)'(2));

    // R6: a redirect requests its target in the same cycle
    p_branch_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |-> mem_req && mem_addr == (br_target & ~ADDR_W'(1)));

    // R7: transfer size follows address bit 1
    p_half_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_size == !mem_addr[1]);

    // R8: program addresses are even
    p_even_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_addr[0] && (!ins_valid || !ins_addr[0]));

    // R9: a refused request is held steady
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> br_valid || (mem_req && $stable(mem_addr) && $stable(mem_size)));

    // R11: offered instruction holds under decode stall
    p_stall_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && !ins_ready && !br_valid |=> ins_valid && $stable(ins_data) && $stable(ins_addr));

endmodule

bind hw_prefetch_unit hw_prefetch_unit_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/hw_prefetch_unit_tb_top.sv
module hw_prefetch_unit_tb_top;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_size;
    logic          mem_ready = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          ins_valid;
    logic          ins_ready = 1'b0;
    logic [15:0]   ins_data;
    logic [AW-1:0] ins_addr;
    logic          br_valid = 1'b0;
    logic [AW-1:0] br_target = '0;

    int unsigned vectors = 0;
    int unsigned miscompares = 0;
    int unsigned acc_count = 0;
    int unsigned valid_count = 0;

    logic [AW-1:0] exp_addr = '0;
    logic [AW-1:0] exp_fetch = '0;
    logic          rsp_pending = 1'b0;
    logic [AW-1:0] rsp_addr_b = '0;
    logic          after_branch = 1'b0;

    always #5 clk = ~clk;

    hw_prefetch_unit #(.ADDR_W(AW), .RESET_ADDR('0)) dut_i (.*);

    function automatic logic [15:0] hw_of(input logic [AW-1:0] a);
        return a[16:1] ^ 16'h5A3C;
    endfunction

    function automatic logic [31:0] word_of(input logic [AW-1:0] a);
        logic [AW-1:0] base;
        base = a & ~AW'(3);
        return {hw_of(base + AW'(2)), hw_of(base)};
    endfunction

    task automatic check(input string tag, input bit ok,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: called just after a falling edge, returns after the next one
    task automatic run_cycle(input bit mr, input bit ir, input bit bv, input logic [AW-1:0] bt);
        logic [AW-1:0] tgt;
        logic [AW-1:0] want;
        tgt       = bt & ~AW'(1);
        mem_ready = mr;
        ins_ready = ir;
        br_valid  = bv;
        br_target = bt;
        mem_rdata = rsp_pending ? word_of(rsp_addr_b) : 32'hDEAD_BEEF;
        #1;
        if (ins_valid) begin
            check(after_branch ? "R5 addr" : "R2 addr", ins_addr == exp_addr, ins_addr, exp_addr);
            check("R2 data", ins_data == hw_of(exp_addr), {16'h0, ins_data}, {16'h0, hw_of(exp_addr)});
            valid_count++;
        end
        want = bv ? tgt : exp_fetch;
        if (bv) check("R6 req", mem_req == 1'b1, {31'h0, mem_req}, 32'h1);
        if (mem_req) begin
            check(bv ? "R6 addr" : "R8 addr", mem_addr == want, mem_addr, want);
            check("R7 size", mem_size == !want[1], {31'h0, mem_size}, {31'h0, !want[1]});
        end
        @(posedge clk);
        if (bv) begin
            exp_addr     = tgt;
            after_branch = 1'b1;
        end else if (ins_valid && ins_ready) begin
            exp_addr     = exp_addr + AW'(2);
            after_branch = 1'b0;
        end
        if (mem_req && mr) begin
            acc_count++;
            exp_fetch   = want + (want[1] ? AW'(2) : AW'(4));
            rsp_pending = 1'b1;
            rsp_addr_b  = want;
        end else begin
            exp_fetch   = want;
            rsp_pending = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [AW-1:0] held;
        int unsigned   a0;
        int unsigned   v0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 valid", ins_valid == 1'b0, {31'h0, ins_valid}, 32'h0);
        check("R1 req", mem_req == 1'b1 && mem_size == 1'b1, {30'h0, mem_req, mem_size}, 32'h3);
        check("R1 addr", mem_addr == '0, mem_addr, 32'h0);
        @(negedge clk);
        // R1 step consumed one cycle without driving; redo the fetch model from reset
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R3: straight-line run, 40 cycles
        a0 = acc_count;
        run_cycle(1'b1, 1'b1, 1'b0, '0);
        check("R3 reads", acc_count - a0 == 1, acc_count - a0, 1);
        a0 = acc_count;
        v0 = valid_count;
        for (int i = 0; i < 40; i++) run_cycle(1'b1, 1'b1, 1'b0, '0);
        check("R3 valid cycles", valid_count - v0 == 40, valid_count - v0, 40);
        check("R3 reads", acc_count - a0 == 20, acc_count - a0, 20);

        // R4/R11: decode stall holds instructions and stops reads
        a0 = acc_count;
        held = ins_addr;
        for (int i = 0; i < 6; i++) begin
            run_cycle(1'b1, 1'b0, 1'b0, '0);
            check("R11 hold", ins_valid && ins_addr == held, ins_addr, held);
        end
        check("R4 no read", acc_count == a0, acc_count - a0, 0);

        // R9: memory not ready, request held
        for (int i = 0; i < 5; i++) run_cycle(1'b0, 1'b1, 1'b0, '0);
        for (int i = 0; i < 6; i++) run_cycle(1'b1, 1'b1, 1'b0, '0);

        // R6: aligned target, valid one cycle later
        run_cycle(1'b1, 1'b1, 1'b1, 32'h200);
        #0;
        mem_rdata = word_of(rsp_addr_b);
        #1;
        check("R6 latency", ins_valid && ins_addr == 32'h200, ins_addr, 32'h200);
        for (int i = 0; i < 6; i++) run_cycle(1'b1, 1'b1, 1'b0, '0);

        // R7: unaligned target, halfword transfer then word reads
        v0 = valid_count;
        run_cycle(1'b1, 1'b1, 1'b1, 32'h30A);
        for (int i = 0; i < 6; i++) run_cycle(1'b1, 1'b1, 1'b0, '0);
        check("R7 throughput", valid_count - v0 == 7, valid_count - v0, 7);

        // R8: bit 0 of the target ignored
        run_cycle(1'b1, 1'b1, 1'b1, 32'h441);
        for (int i = 0; i < 4; i++) run_cycle(1'b1, 1'b1, 1'b0, '0);

        // R10: back-to-back redirects
        run_cycle(1'b1, 1'b1, 1'b1, 32'h400);
        run_cycle(1'b1, 1'b1, 1'b1, 32'h51E);
        run_cycle(1'b1, 1'b1, 1'b1, 32'h624);
        #1;
        check("R10 last target", ins_valid && ins_addr == 32'h624, ins_addr, 32'h624);
        for (int i = 0; i < 5; i++) run_cycle(1'b1, 1'b1, 1'b0, '0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            run_cycle(($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 20) == 0,
                      AW'($urandom % 32'h2000));
        end
        report();
    end

endmodule